// File: doc/BRIEF.md
# Dual-Rail Power Sequencer and Fault Supervisor

This block is the digital controller of a two-output display supply that makes one positive rail and one negative rail. It reads synchronous comparator flags and drives enable, soft-start and discharge controls for both converters. When the enable level is high and the input supply is not under its lockout level, the positive rail starts at once in soft start. A fixed number of millisecond ticks later the negative rail is enabled at its default level. The block then checks both rails at two staggered deadlines.

Once both rails are up, the block watches two droop flags. A flag that stays set through more than a set number of consecutive ticks shuts the supply down. An over-temperature flag shuts it down at any time. Every fault is latched together with a code that names the first cause. Only a low level on enable or an undervoltage event clears the latch. While the block is off or faulted, both outputs are actively discharged. All time spans are counted from a 1 ms tick input and are set by parameters.

Top module: `dual_rail_seq`

## Requirements
- R1: While reset is held, and just after it is released, all rail enables and soft-start outputs are low, both discharge outputs are high, `fault` is low and `fault_cause` is 0.
- R2: With `enable` high and `in_uv` high, the block stays off with both discharges asserted.
- R3: One clock after `enable` is high with `in_uv` low and `over_temp` low, `pos_en` and `pos_ss` go high, both discharges drop, and the negative rail stays disabled. At most one of the two soft-start outputs is high at any time.
- R4: At the T_NEG_MS-th tick (default 10) after start, if `pos_good` is high and `neg_err` is low, `neg_en` and `neg_ss` go high and `pos_ss` goes low. The negative rail is never enabled without the positive rail.
- R5: If `pos_good` is low at the T_NEG_MS-th tick, the block latches a fault with cause code 1.
- R6: If `pos_good` is high but `neg_err` is high at the T_NEG_MS-th tick, the block latches a fault with cause code 2.
- R7: At the T_DONE_MS-th tick (default 20), a low `neg_good` latches a fault with cause code 3. Otherwise the block enters running: both enables stay high and both soft-start outputs go low.
- R8: While running, `pos_low` held high at PERSIST_MS+1 consecutive ticks (default 4) latches cause code 4. Any cycle in which the flag is low restarts the count.
- R9: While running, `neg_err` held high in the same way latches cause code 5. If both flags trip on the same tick, the cause is 4.
- R10: `over_temp` high with `enable` high and `in_uv` low latches cause code 6 on the next clock, from the off state or from any start or run state. A cause that is already latched is kept.
- R11: A latched fault drives all enables and soft-starts low and both discharges high. It holds `fault` and `fault_cause` unchanged, whatever the rail flags do, until `enable` goes low or `in_uv` goes high.
- R12: `enable` low or `in_uv` high returns the block to off on the next clock from any state, clearing `fault` and `fault_cause` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ms_tick | input | 1 | One-cycle pulse every millisecond |
| enable | input | 1 | Supply enable level |
| in_uv | input | 1 | Input supply below lockout level |
| over_temp | input | 1 | Junction over-temperature flag |
| pos_good | input | 1 | Positive rail in regulation |
| pos_low | input | 1 | Positive rail below its droop threshold |
| neg_good | input | 1 | Negative rail in regulation |
| neg_err | input | 1 | Negative rail above its error threshold |
| pos_en | output | 1 | Positive converter enable |
| pos_ss | output | 1 | Positive converter soft-start (reduced current limit) |
| neg_en | output | 1 | Negative converter enable |
| neg_ss | output | 1 | Negative converter ramp to default level |
| pos_dis | output | 1 | Positive output discharge request |
| neg_dis | output | 1 | Negative output discharge request |
| fault | output | 1 | Fault latched |
| fault_cause | output | 3 | Code of first fault: 0 none, 1..6 as in R5 to R10 |

## Verification
The hardest condition to reach is a droop fault while running, because it needs a full start through both deadlines first, with the rail flags changed at the right tick. The stimulus table keeps state from one row to the next, so each row supplies a level pattern and a tick count that walk the sequencer through start, into running and then into a persistence window. One row clears the flag part-way through the window to restart its count. Another raises both droop flags together to check the priority between them.

// File: rtl/drs_pkg.sv
package drs_pkg;

  typedef enum logic [2:0] {
    ST_OFF       = 3'd0,
    ST_POS_START = 3'd1,
    ST_NEG_START = 3'd2,
    ST_RUN       = 3'd3,
    ST_FAULT     = 3'd4
  } seq_state_t;

  typedef enum logic [2:0] {
    CAUSE_NONE      = 3'd0,
    CAUSE_POS_LATE  = 3'd1,
    CAUSE_NEG_EARLY = 3'd2,
    CAUSE_NEG_LATE  = 3'd3,
    CAUSE_POS_DROOP = 3'd4,
    CAUSE_NEG_DROOP = 3'd5,
    CAUSE_THERMAL   = 3'd6
  } fault_cause_t;

endpackage

// File: rtl/drs_start_timer.sv
module drs_start_timer #(
  parameter int T_NEG_MS  = 10,
  parameter int T_DONE_MS = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic tick,
  output logic hit_neg,
  output logic hit_done
);
  localparam int CW = $clog2(T_DONE_MS + 1);
  localparam logic [CW-1:0] NEG_LAST  = CW'(T_NEG_MS - 1);
  localparam logic [CW-1:0] DONE_LAST = CW'(T_DONE_MS - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (!run) begin
      cnt_q <= '0;
    end else if (tick && cnt_q != DONE_LAST) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign hit_neg  = run && tick && (cnt_q == NEG_LAST);
  assign hit_done = run && tick && (cnt_q == DONE_LAST);
endmodule

// File: rtl/drs_persist_filter.sv
module drs_persist_filter #(
  parameter int PERSIST_MS = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic flag,
  input  logic tick,
  output logic trip
);
  localparam int PW = $clog2(PERSIST_MS + 1);
  localparam logic [PW-1:0] LIMIT = PW'(PERSIST_MS);

  logic [PW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (!arm || !flag) begin
      cnt_q <= '0;
    end else if (tick && cnt_q != LIMIT) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign trip = arm && flag && tick && (cnt_q == LIMIT);
endmodule

// File: rtl/dual_rail_seq.sv
module dual_rail_seq
  import drs_pkg::*;
#(
  parameter int T_NEG_MS   = 10,
  parameter int T_DONE_MS  = 20,
  parameter int PERSIST_MS = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ms_tick,
  input  logic       enable,
  input  logic       in_uv,
  input  logic       over_temp,
  input  logic       pos_good,
  input  logic       pos_low,
  input  logic       neg_good,
  input  logic       neg_err,
  output logic       pos_en,
  output logic       pos_ss,
  output logic       neg_en,
  output logic       neg_ss,
  output logic       pos_dis,
  output logic       neg_dis,
  output logic       fault,
  output logic [2:0] fault_cause
);
  localparam int NMON = 2;

  seq_state_t   st_q, st_d;
  fault_cause_t cause_q, cause_d;

  logic hit_neg, hit_done;
  logic [NMON-1:0] mon_flag;
  logic [NMON-1:0] mon_trip;
  logic in_start, in_run;

  assign in_start = (st_q == ST_POS_START) || (st_q == ST_NEG_START);
  assign in_run   = (st_q == ST_RUN);

  drs_start_timer #(
    .T_NEG_MS (T_NEG_MS),
    .T_DONE_MS(T_DONE_MS)
  ) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (in_start),
    .tick    (ms_tick),
    .hit_neg (hit_neg),
    .hit_done(hit_done)
  );

  // index 0 watches the positive droop, index 1 the negative error
  assign mon_flag = {neg_err, pos_low};

  for (genvar g = 0; g < NMON; g++) begin : g_mon
    drs_persist_filter #(
      .PERSIST_MS(PERSIST_MS)
    ) u_filt (
      .clk  (clk),
      .rst_n(rst_n),
      .arm  (in_run),
      .flag (mon_flag[g]),
      .tick (ms_tick),
      .trip (mon_trip[g])
    );
  end

  always_comb begin
    st_d    = st_q;
    cause_d = cause_q;
    if (!enable || in_uv) begin
      st_d    = ST_OFF;
      cause_d = CAUSE_NONE;
    end else if (over_temp && st_q != ST_FAULT) begin
      st_d    = ST_FAULT;
      cause_d = CAUSE_THERMAL;
    end else begin
      unique case (st_q)
        ST_OFF: st_d = ST_POS_START;
        ST_POS_START: begin
          if (hit_neg) begin
            if (!pos_good) begin
              st_d    = ST_FAULT;
              cause_d = CAUSE_POS_LATE;
            end else if (neg_err) begin
              st_d    = ST_FAULT;
              cause_d = CAUSE_NEG_EARLY;
            end else begin
              st_d = ST_NEG_START;
            end
          end
        end
        ST_NEG_START: begin
          if (hit_done) begin
            if (!neg_good) begin
              st_d    = ST_FAULT;
              cause_d = CAUSE_NEG_LATE;
            end else begin
              st_d = ST_RUN;
            end
          end
        end
        ST_RUN: begin
          if (mon_trip[0]) begin
            st_d    = ST_FAULT;
            cause_d = CAUSE_POS_DROOP;
          end else if (mon_trip[1]) begin
            st_d    = ST_FAULT;
            cause_d = CAUSE_NEG_DROOP;
          end
        end
        ST_FAULT: st_d = ST_FAULT;
        default: begin
          st_d    = ST_OFF;
          cause_d = CAUSE_NONE;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_OFF;
      cause_q <= CAUSE_NONE;
    end else begin
      st_q    <= st_d;
      cause_q <= cause_d;
    end
  end

  assign pos_en      = in_start || in_run;
  assign pos_ss      = (st_q == ST_POS_START);
  assign neg_en      = (st_q == ST_NEG_START) || in_run;
  assign neg_ss      = (st_q == ST_NEG_START);
  assign pos_dis     = (st_q == ST_OFF) || (st_q == ST_FAULT);
  assign neg_dis     = pos_dis;
  assign fault       = (st_q == ST_FAULT);
  assign fault_cause = cause_q;
endmodule

// File: rtl/dual_rail_seq_chk.sv
module dual_rail_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       enable,
  input logic       in_uv,
  input logic       over_temp,
  input logic       pos_en,
  input logic       pos_ss,
  input logic       neg_en,
  input logic       neg_ss,
  input logic       pos_dis,
  input logic       neg_dis,
  input logic       fault,
  input logic [2:0] fault_cause
);
  AST_NEG_NEEDS_POS: assert property (@(posedge clk) disable iff (!rst_n)
    neg_en |-> pos_en); // R4

  AST_NEG_AFTER_SS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(neg_en) |-> $past(pos_ss)); // R4

  AST_SS_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({pos_ss, neg_ss})); // R3

  AST_START_NOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!pos_en && !fault && enable && !in_uv && !over_temp) |=> (pos_en && pos_ss && !neg_en)); // R3

  AST_DIS_SAFE: assert property (@(posedge clk) disable iff (!rst_n)
    (pos_dis || neg_dis) |-> (!pos_en && !neg_en)); // R11

  AST_FAULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (fault && enable && !in_uv) |=> (fault && $stable(fault_cause))); // R11

  AST_FAULT_CODED: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> (fault_cause != 3'd0)); // R5

  AST_THERMAL_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    (over_temp && enable && !in_uv) |=> (fault && !pos_en && !neg_en)); // R10

  AST_SHUTDOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable || in_uv) |=> (!pos_en && !neg_en && !fault && fault_cause == 3'd0)); // R12
endmodule

bind dual_rail_seq dual_rail_seq_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .enable     (enable),
  .in_uv      (in_uv),
  .over_temp  (over_temp),
  .pos_en     (pos_en),
  .pos_ss     (pos_ss),
  .neg_en     (neg_en),
  .neg_ss     (neg_ss),
  .pos_dis    (pos_dis),
  .neg_dis    (neg_dis),
  .fault      (fault),
  .fault_cause(fault_cause)
);

// File: tb/dual_rail_seq_tb.sv
module dual_rail_seq_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ms_tick = 1'b0;
  logic enable = 1'b0, in_uv = 1'b0, over_temp = 1'b0;
  logic pos_good = 1'b0, pos_low = 1'b0, neg_good = 1'b0, neg_err = 1'b0;
  logic pos_en, pos_ss, neg_en, neg_ss, pos_dis, neg_dis, fault;
  logic [2:0] fault_cause;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  dual_rail_seq u_dut (
    .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .enable(enable),
    .in_uv(in_uv), .over_temp(over_temp), .pos_good(pos_good),
    .pos_low(pos_low), .neg_good(neg_good), .neg_err(neg_err),
    .pos_en(pos_en), .pos_ss(pos_ss), .neg_en(neg_en), .neg_ss(neg_ss),
    .pos_dis(pos_dis), .neg_dis(neg_dis), .fault(fault),
    .fault_cause(fault_cause)
  );

  // row: {en,uv,ot,pg,pl,ng,ne}[27:21] ticks[20:13]
  //      exp {pos_en,pos_ss,neg_en,neg_ss,dis,fault}[12:7] cause[6:4] tag[3:0]
  localparam int NROW = 35;
  localparam logic [27:0] ROWS [NROW] = '{
    {7'b0000000, 8'd0,  6'b000010, 3'd0, 4'd12}, // R12 off
    {7'b1100000, 8'd0,  6'b000010, 3'd0, 4'd2},  // R2 uv blocks start
    {7'b1000000, 8'd0,  6'b110000, 3'd0, 4'd3},  // R3 positive start
    {7'b1001000, 8'd9,  6'b110000, 3'd0, 4'd4},  // R4 before 10 ms
    {7'b1001000, 8'd1,  6'b101100, 3'd0, 4'd4},  // R4 negative start
    {7'b1001010, 8'd9,  6'b101100, 3'd0, 4'd7},  // R7 before 20 ms
    {7'b1001010, 8'd1,  6'b101000, 3'd0, 4'd7},  // R7 running
    {7'b1001110, 8'd3,  6'b101000, 3'd0, 4'd8},  // R8 3 ticks only
    {7'b1001010, 8'd1,  6'b101000, 3'd0, 4'd8},  // R8 flag clears
    {7'b1001110, 8'd3,  6'b101000, 3'd0, 4'd8},  // R8 count restarted
    {7'b1001110, 8'd1,  6'b000011, 3'd4, 4'd8},  // R8 trip
    {7'b1001010, 8'd5,  6'b000011, 3'd4, 4'd11}, // R11 hold
    {7'b0000000, 8'd0,  6'b000010, 3'd0, 4'd11}, // R11 cleared by enable low
    {7'b1000000, 8'd10, 6'b000011, 3'd1, 4'd5},  // R5 pos late
    {7'b1100000, 8'd0,  6'b000010, 3'd0, 4'd12}, // R12 uv clears
    {7'b1001001, 8'd10, 6'b000011, 3'd2, 4'd6},  // R6 neg early
    {7'b0000000, 8'd0,  6'b000010, 3'd0, 4'd12},
    {7'b1001000, 8'd20, 6'b000011, 3'd3, 4'd7},  // R7 neg late
    {7'b0000000, 8'd0,  6'b000010, 3'd0, 4'd12},
    {7'b1001010, 8'd20, 6'b101000, 3'd0, 4'd7},  // R7
    {7'b1001111, 8'd4,  6'b000011, 3'd4, 4'd9},  // R9 both trip, pos wins
    {7'b0000000, 8'd0,  6'b000010, 3'd0, 4'd11},
    {7'b1001010, 8'd20, 6'b101000, 3'd0, 4'd7},
    {7'b1001011, 8'd4,  6'b000011, 3'd5, 4'd9},  // R9 neg droop
    {7'b0000000, 8'd0,  6'b000010, 3'd0, 4'd12},
    {7'b1001000, 8'd3,  6'b110000, 3'd0, 4'd3},
    {7'b1011000, 8'd0,  6'b000011, 3'd6, 4'd10}, // R10 thermal in start
    {7'b1001000, 8'd2,  6'b000011, 3'd6, 4'd10}, // R10 stays latched
    {7'b0000000, 8'd0,  6'b000010, 3'd0, 4'd12},
    {7'b1010000, 8'd0,  6'b000011, 3'd6, 4'd10}, // R10 thermal from off
    {7'b0000000, 8'd0,  6'b000010, 3'd0, 4'd12},
    {7'b1001010, 8'd5,  6'b110000, 3'd0, 4'd3},
    {7'b1101010, 8'd0,  6'b000010, 3'd0, 4'd12}, // R12 uv during start
    {7'b1001010, 8'd20, 6'b101000, 3'd0, 4'd7},
    {7'b0001010, 8'd0,  6'b000010, 3'd0, 4'd12}  // R12 enable low in run
  };

  task automatic check_out(input logic [5:0] exp, input logic [2:0] ecause, input int tag);
    logic [6:0] act;
    act = {pos_en, pos_ss, neg_en, neg_ss, pos_dis, fault, neg_dis};
    checks++;
    if (act != {exp, exp[1]} || fault_cause != ecause) begin
      failures++;
      $display("FAIL R%0d outputs=%b cause=%0d expected=%b cause=%0d",
               tag, act, fault_cause, {exp, exp[1]}, ecause);
    end
  endtask

  task automatic give_ticks(input int n);
    for (int i = 0; i < n; i++) begin
      ms_tick = 1'b1;
      @(negedge clk);
      ms_tick = 1'b0;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check_out(6'b000010, 3'd0, 1); // R1 during reset
    rst_n = 1'b1;
    @(negedge clk);
    check_out(6'b000010, 3'd0, 1); // R1 after release

    for (int r = 0; r < NROW; r++) begin
      {enable, in_uv, over_temp, pos_good, pos_low, neg_good, neg_err} = ROWS[r][27:21];
      @(negedge clk);
      give_ticks(int'(ROWS[r][20:13]));
      repeat (2) @(negedge clk);
      check_out(ROWS[r][12:7], ROWS[r][6:4], int'(ROWS[r][3:0]));
    end

    // R1: reset in the middle of running
    {enable, in_uv, over_temp, pos_good, pos_low, neg_good, neg_err} = 7'b1001010;
    @(negedge clk);
    give_ticks(20);
    @(negedge clk);
    check_out(6'b101000, 3'd0, 7); // R7
    rst_n = 1'b0;
    @(negedge clk);
    check_out(6'b000010, 3'd0, 1); // R1
    enable = 1'b0;
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R8: droop flag toggling every tick never trips
    {enable, in_uv, over_temp, pos_good, pos_low, neg_good, neg_err} = 7'b1001010;
    @(negedge clk);
    give_ticks(20);
    for (int k = 0; k < 6; k++) begin
      pos_low = 1'b1;
      give_ticks(3);
      pos_low = 1'b0;
      @(negedge clk);
    end
    check_out(6'b101000, 3'd0, 8); // R8
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule